// File: doc/BRIEF.md
# EPP Data Cycle Handshake Engine

This block runs Enhanced Parallel Port data-port transfers on behalf of a host. A host read or write aimed at offsets 4 to 7 of the port's address window starts a data cycle. The engine then drives or releases the 8-bit peripheral data bus and lowers its strobes. It waits for the peripheral's handshake input to move, latches the byte and completes the host access. It then waits for the handshake input to return before the next cycle may begin.

The host side uses level strobes. The host holds its read or write strobe until the engine pulses a one-cycle ready, and then it drops the strobe. On the peripheral side there are two registered active-low outputs: a write-direction strobe and a data strobe. The handshake input is active-low and is synchronized inside the block. A programmable watchdog stops any phase that waits too long.

Top module: `epp_data_engine`

## Requirements
- R1: A host strobe starts a cycle only when `host_addr` is 4, 5, 6 or 7 (address bits above bit 1 equal to 1). Strobes to any other address move no peripheral output and give no ready pulse.
- R2: On the first clock edge that samples an accepted write, `pp_dir_wr_n` and `pp_strobe_n` go to 0, `pp_doe` goes to 1 and `pp_dout` takes `host_wdata`.
- R3: In a write, once the synchronized handshake input reads 1, `pp_strobe_n` returns to 1 and `host_rdy` pulses. `pp_dir_wr_n` stays 0 and the byte stays driven on `pp_dout`.
- R4: A write ends only when the synchronized handshake input reads 0 again. At that edge `pp_dir_wr_n` returns to 1 and `pp_doe` to 0.
- R5: On the first edge that samples an accepted read, `pp_strobe_n` goes to 0, `pp_doe` is 0 and `pp_dir_wr_n` stays 1. If both host strobes are high, the write is taken.
- R6: In a read, once the synchronized handshake input reads 1, `pp_din` is captured into `host_rdata` and held there. `pp_strobe_n` returns to 1 and `host_rdy` pulses.
- R7: A read ends when the synchronized handshake input reads 0 again.
- R8: `pp_hshk_n` passes through two flops. A change of that input shows at the registered outputs on the third rising edge after the change, and not before.
- R9: `host_rdy` is 0 from the accepting edge until the latch edge, and it is high for exactly one cycle per host access.
- R10: While a phase waits, let L be a nonzero `tmo_limit`. If the awaited level has not arrived by the L-th edge after the phase began, then on that edge both strobes go to 1, `pp_doe` goes to 0 and `tmo_flag` is set. `tmo_flag` stays set until reset. If the host had not yet been released, `host_rdy` also pulses. A `tmo_limit` of 0 turns the watchdog off.
- R11: A new cycle is accepted only in idle, after the closing handshake edge. The host strobes must also have been low at least once since the last accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Offset within the port window |
| host_rd | input | 1 | Host read strobe, held until ready |
| host_wr | input | 1 | Host write strobe, held until ready |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Byte captured from the peripheral |
| host_rdy | output | 1 | One-cycle completion pulse to the host |
| tmo_limit | input | CNT_W | Watchdog limit in clocks, 0 disables |
| tmo_flag | output | 1 | Sticky watchdog expiry flag |
| pp_dout | output | DATA_W | Peripheral bus output value |
| pp_doe | output | 1 | Peripheral bus output enable |
| pp_din | input | DATA_W | Peripheral bus input value |
| pp_dir_wr_n | output | 1 | Active-low write-direction strobe |
| pp_strobe_n | output | 1 | Active-low data strobe |
| pp_hshk_n | input | 1 | Active-low peripheral handshake input |

## Verification
The sequencer state is visible at the ports almost directly, so a wrong state shows up quickly. A phase entered wrongly shows within one clock as a strobe level or bus enable that does not match the direction. A missed or early latch shows on the third edge after the handshake moves, as a ready pulse that is missing, early or doubled, or as wrong read data. A cycle that closes too soon shows as a second host access being accepted while the handshake input is still high.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_STB,
    ST_WR_END,
    ST_RD_STB,
    ST_RD_END
  } epp_state_e;

  // data port window: offsets 4..7 of the port block
  function automatic logic data_port_hit(input logic [31:0] offs);
    return offs[31:2] == 30'd1;
  endfunction

  // watchdog expires on the lim-th waiting cycle; lim == 0 disables
  function automatic logic tmo_due(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  import epp_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = run && tmo_due(32'(cnt), 32'(limit));
endmodule

// File: rtl/epp_seq.sv
module epp_seq #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic                req_rd,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   pd_in,
  input  logic                wait_s,
  input  logic                tmo_exp,
  output logic [DATA_W-1:0]   pd_out,
  output logic                pd_oe,
  output logic                wr_n,
  output logic                stb_n,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdy,
  output logic                flag,
  output logic                busy,
  output logic                cyc_start,
  output logic                latch_pt,
  output logic                cyc_end,
  output logic                tmo_fire
);
  import epp_pkg::*;

  epp_state_e state;
  logic in_stb, in_end, cond_met;

  assign busy      = (state != ST_IDLE);
  assign in_stb    = (state == ST_WR_STB) || (state == ST_RD_STB);
  assign in_end    = (state == ST_WR_END) || (state == ST_RD_END);
  assign cond_met  = (in_stb && wait_s) || (in_end && !wait_s);
  assign cyc_start = !busy && (req_wr || req_rd);
  assign latch_pt  = in_stb && wait_s;
  assign cyc_end   = in_end && !wait_s;
  assign tmo_fire  = busy && !cond_met && tmo_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pd_out <= '0;
      pd_oe  <= 1'b0;
      wr_n   <= 1'b1;
      stb_n  <= 1'b1;
      rdata  <= '0;
      rdy    <= 1'b0;
      flag   <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (tmo_fire) begin
        state <= ST_IDLE;
        pd_oe <= 1'b0;
        wr_n  <= 1'b1;
        stb_n <= 1'b1;
        flag  <= 1'b1;
        rdy   <= in_stb;
      end else begin
        case (state)
          ST_IDLE: begin
            if (req_wr) begin
              state  <= ST_WR_STB;
              pd_out <= wdata;
              pd_oe  <= 1'b1;
              wr_n   <= 1'b0;
              stb_n  <= 1'b0;
            end else if (req_rd) begin
              state <= ST_RD_STB;
              pd_oe <= 1'b0;
              stb_n <= 1'b0;
            end
          end
          ST_WR_STB: if (wait_s) begin
            state <= ST_WR_END;
            stb_n <= 1'b1;
            rdy   <= 1'b1;
          end
          ST_WR_END: if (!wait_s) begin
            state <= ST_IDLE;
            wr_n  <= 1'b1;
            pd_oe <= 1'b0;
          end
          ST_RD_STB: if (wait_s) begin
            state <= ST_RD_END;
            rdata <= pd_in;
            stb_n <= 1'b1;
            rdy   <= 1'b1;
          end
          ST_RD_END: if (!wait_s) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/epp_data_engine.sv
module epp_data_engine #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdy,
  input  logic [CNT_W-1:0]  tmo_limit,
  output logic              tmo_flag,
  output logic [DATA_W-1:0] pp_dout,
  output logic              pp_doe,
  input  logic [DATA_W-1:0] pp_din,
  output logic              pp_dir_wr_n,
  output logic              pp_strobe_n,
  input  logic              pp_hshk_n
);
  import epp_pkg::*;

  // named internal events, observed by the bound checker
  logic hit, armed, req_wr, req_rd, wait_s, tmo_exp;
  logic busy, cyc_start, latch_pt, cyc_end, tmo_fire;

  assign hit    = data_port_hit(32'(host_addr));
  assign req_wr = armed && hit && host_wr;
  assign req_rd = armed && hit && host_rd && !host_wr;

  // host must drop its strobes once before another cycle is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b1;
    else if (cyc_start) armed <= 1'b0;
    else if (!host_rd && !host_wr) armed <= 1'b1;
  end

  epp_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pp_hshk_n), .q(wait_s)
  );

  epp_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(cyc_start || latch_pt),
    .run(busy),
    .limit(tmo_limit),
    .expired(tmo_exp)
  );

  epp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .req_rd(req_rd),
    .wdata(host_wdata), .pd_in(pp_din),
    .wait_s(wait_s), .tmo_exp(tmo_exp),
    .pd_out(pp_dout), .pd_oe(pp_doe),
    .wr_n(pp_dir_wr_n), .stb_n(pp_strobe_n),
    .rdata(host_rdata), .rdy(host_rdy), .flag(tmo_flag),
    .busy(busy), .cyc_start(cyc_start), .latch_pt(latch_pt),
    .cyc_end(cyc_end), .tmo_fire(tmo_fire)
  );
endmodule

// File: rtl/epp_data_engine_chk.sv
module epp_data_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic pp_dir_wr_n,
  input logic pp_strobe_n,
  input logic pp_doe,
  input logic host_rdy,
  input logic tmo_flag,
  input logic busy,
  input logic cyc_start,
  input logic cyc_end,
  input logic tmo_fire
);
  a_r2_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_dir_wr_n |-> pp_doe);

  a_r5_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_strobe_n && pp_dir_wr_n) |-> !pp_doe);

  a_r9_ready_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |=> !host_rdy);

  a_r3_ready_with_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> pp_strobe_n);

  a_r11_start_lowers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (!pp_strobe_n && busy));

  a_r4_end_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (pp_dir_wr_n && pp_strobe_n && !pp_doe && !busy));

  a_r10_fire_idles_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (pp_dir_wr_n && pp_strobe_n && !pp_doe && tmo_flag));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag);
endmodule

bind epp_data_engine epp_data_engine_chk u_chk (.*);

// File: tb/epp_data_engine_bench.sv
`timescale 1ns/100ps
module epp_data_engine_bench;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [DATA_W-1:0] host_wdata = '0, host_rdata;
  logic host_rdy, tmo_flag, pp_doe, pp_dir_wr_n, pp_strobe_n;
  logic [CNT_W-1:0] tmo_limit = 8'd20;
  logic [DATA_W-1:0] pp_dout, pp_din = '0;
  logic pp_hshk_n = 1'b0;

  typedef struct { bit is_tmo; bit is_rd; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  epp_data_engine u_epp_data_engine (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic after_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: every ready pulse consumes one expected item
  always @(posedge clk) begin : mon
    exp_t e;
    #1;
    if (rst_n && host_rdy) begin
      if (exp_q.size() == 0) chk("R9 unexpected ready", 1, 0);
      else begin
        e = exp_q.pop_front();
        if (e.is_tmo) chk("R10 flag at timeout ready", tmo_flag, 1);
        else if (e.is_rd) chk("R6 read data", host_rdata, e.data);
        else begin
          chk("R3 write byte held", pp_dout, e.data);
          chk("R3 bus still driven", pp_doe, 1);
        end
      end
    end
  end

  task automatic write_cycle(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    exp_q.push_back('{0, 0, d});
    after_edges(1);
    chk("R2 dir strobe low", pp_dir_wr_n, 0);
    chk("R2 data strobe low", pp_strobe_n, 0);
    chk("R2 bus enabled", pp_doe, 1);
    chk("R2 bus value", pp_dout, d);
    after_edges(3);
    chk("R9 host stalled", host_rdy, 0);
    @(negedge clk); pp_hshk_n = 1'b1;
    after_edges(2);
    chk("R8 no early response", pp_strobe_n, 0);
    after_edges(1);
    chk("R3 data strobe off", pp_strobe_n, 1);
    chk("R3 ready pulse", host_rdy, 1);
    chk("R3 dir strobe kept", pp_dir_wr_n, 0);
    @(negedge clk); host_wr = 1'b0;
    after_edges(2);
    chk("R4 not closed early", pp_dir_wr_n, 0);
    @(negedge clk); pp_hshk_n = 1'b0;
    after_edges(3);
    chk("R4 dir strobe off", pp_dir_wr_n, 1);
    chk("R4 bus released", pp_doe, 0);
  endtask

  task automatic read_to_latch(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; pp_din = ~d;
    exp_q.push_back('{0, 1, d});
    after_edges(1);
    chk("R5 data strobe low", pp_strobe_n, 0);
    chk("R5 bus released", pp_doe, 0);
    chk("R5 dir strobe high", pp_dir_wr_n, 1);
    @(negedge clk); pp_din = d; pp_hshk_n = 1'b1;
    after_edges(3);
    chk("R6 strobe off", pp_strobe_n, 1);
    chk("R6 ready", host_rdy, 1);
    @(negedge clk); host_rd = 1'b0; pp_din = 8'h00;
  endtask

  task automatic read_cycle(input logic [2:0] a, input logic [7:0] d);
    read_to_latch(a, d);
    @(negedge clk); pp_hshk_n = 1'b0;
    after_edges(3);
    chk("R6 read data held", host_rdata, d);
    chk("R7 idle strobes", pp_strobe_n, 1);
  endtask

  initial begin
    after_edges(2);
    chk("R10 reset flag", tmo_flag, 0);
    chk("R4 reset dir strobe", pp_dir_wr_n, 1);
    chk("R4 reset data strobe", pp_strobe_n, 1);
    chk("R9 reset ready", host_rdy, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: outside the data port window
    @(negedge clk); host_addr = 3'd3; host_wr = 1'b1;
    after_edges(5);
    chk("R1 addr3 no strobe", pp_strobe_n, 1);
    chk("R1 addr3 no dir", pp_dir_wr_n, 1);
    @(negedge clk); host_wr = 1'b0; host_addr = 3'd0; host_rd = 1'b1;
    after_edges(5);
    chk("R1 addr0 no strobe", pp_strobe_n, 1);
    @(negedge clk); host_rd = 1'b0;

    write_cycle(3'd4, 8'hA5);
    read_cycle(3'd7, 8'h96);
    write_cycle(3'd6, 8'h3C);
    read_cycle(3'd5, 8'h0F);

    // R11 / R7: next request waits for the closing edge
    read_to_latch(3'd4, 8'hC3);
    @(negedge clk); host_addr = 3'd5; host_wdata = 8'h71; host_wr = 1'b1;
    exp_q.push_back('{0, 0, 8'h71});
    after_edges(4);
    chk("R11 held off before close", pp_dir_wr_n, 1);
    @(negedge clk); pp_hshk_n = 1'b0;
    after_edges(3);
    chk("R7 close edge reached", pp_dir_wr_n, 1);
    after_edges(1);
    chk("R11 accepted after close", pp_dir_wr_n, 0);
    @(negedge clk); pp_hshk_n = 1'b1;
    after_edges(3);
    chk("R3 ready second write", host_rdy, 1);
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk); pp_hshk_n = 1'b0;
    after_edges(3);

    // R10: watchdog with limit 6 in the strobe phase
    @(negedge clk); tmo_limit = 8'd6; host_addr = 3'd6; host_wdata = 8'h5A; host_wr = 1'b1;
    exp_q.push_back('{1, 0, 8'h00});
    after_edges(1);
    chk("R2 strobe low before timeout", pp_strobe_n, 0);
    after_edges(5);
    chk("R10 no ready before limit", host_rdy, 0);
    chk("R10 strobe kept before limit", pp_strobe_n, 0);
    after_edges(1);
    chk("R10 ready at limit", host_rdy, 1);
    chk("R10 strobe idle", pp_strobe_n, 1);
    chk("R10 dir idle", pp_dir_wr_n, 1);
    chk("R10 bus released", pp_doe, 0);
    chk("R10 flag set", tmo_flag, 1);
    after_edges(3);
    chk("R11 held strobe not retaken", pp_dir_wr_n, 1);
    @(negedge clk); host_wr = 1'b0; tmo_limit = 8'd20;
    read_cycle(3'd7, 8'hE1);
    chk("R10 flag sticky", tmo_flag, 1);

    // R10: limit 0 disables the watchdog
    @(negedge clk); tmo_limit = 8'd0; host_addr = 3'd4; host_wdata = 8'h44; host_wr = 1'b1;
    exp_q.push_back('{0, 0, 8'h44});
    after_edges(40);
    chk("R10 disabled still waiting", pp_strobe_n, 0);
    @(negedge clk); pp_hshk_n = 1'b1;
    after_edges(3);
    chk("R10 disabled completes", host_rdy, 1);
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk); pp_hshk_n = 1'b0;
    after_edges(3);

    chk("R9 all accesses completed", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule